// File: doc/BRIEF.md
# Single-Wire Timebase Clock Divider

This block derives a 1 MHz enable tick from the system clock for a single-wire bus timing engine. Software programs a 5-bit divisor value through a write strobe. The block splits the division into two cascaded stages. An odd prescaler divides by 1, 3, 5 or 7. A power-of-two stage then divides the prescaler output by 2^n. Together the two stages cover system clocks from 4 MHz up to 128 MHz with an exact microsecond tick.

The total division is N = (2k+1) * 2^n, where k is the prescale code and n is the power field. The tick is a pulse one system clock wide, produced once every N cycles. Writing the divisor register restarts both counters. The first tick after a write therefore arrives a fixed, known number of cycles later. The block does not divide by fractions and does not gate the clock.

Top module: `swt_clkdiv`

## Requirements
- R1: After reset the divisor register holds 0, and `tick_o` is high in every cycle from the first clock edge after reset release.
- R2: The divisor bits [1:0] hold a code k that selects a prescale of 2k+1 (0→1, 1→3, 2→5, 3→7). Bits [4:2] hold n and select a further division by 2^n. The tick period is N = (2k+1)*2^n cycles.
- R3: When N > 1, `tick_o` is high for exactly one cycle and then low for N-1 cycles.
- R4: A write with `div_we_i` high at clock edge E forces `tick_o` low in the cycle after E. The first tick then appears in the cycle after edge E+N.
- R5: The values 0x08, 0x02, 0x05, 0x03, 0x0C, 0x06, 0x09, 0x10, 0x0A, 0x0D, 0x14, 0x18 and 0x1C divide by 4, 5, 6, 7, 8, 10, 12, 16, 20, 24, 32, 64 and 128. For the clock frequency matching each of these, the tick interval is 1 µs.
- R6: Divisor 0x00 divides by 1, so `tick_o` stays high in every cycle.
- R7: The largest value, 0x1F, divides by 7*128 = 896.
- R8: A write in the middle of a count discards the partial count, whether the value is the same or different. The next tick follows the timing of R4 for the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Divisor register write strobe |
| div_wdata_i | input | 5 | Divisor value: [1:0] prescale code, [4:2] power-of-two exponent |
| tick_o | output | 1 | One-cycle enable tick every N cycles |

## Verification
A prescale counter that wraps at the wrong value, or a power stage with the wrong limit, changes the spacing between ticks. This shows at the port within one tick period, at most 896 cycles. A counter that is not cleared on a write shows up in a different way: the first tick after the write arrives early or late. The bench measures both the distance from the write edge to the first tick and the following period for every value in the supported set. It also rewrites the divisor in the middle of a count to catch a missed restart.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int unsigned PRE_W = 2;
  localparam int unsigned POW_W = 3;
  localparam int unsigned DIV_W = PRE_W + POW_W;
  localparam int unsigned PRE_CNT_W = PRE_W + 1;
  localparam int unsigned POW_CNT_W = (1 << POW_W) - 1;

  typedef struct packed {
    logic [POW_W-1:0] pow;
    logic [PRE_W-1:0] pre;
  } div_t;

  // prescale terminal count: factor 2k+1 -> limit 2k
  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
    return {code, 1'b0};
  endfunction
endpackage

// File: rtl/swt_prescale.sv
module swt_prescale
  import swt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             pre_tick_o
);
  logic [PRE_CNT_W-1:0] cnt_q;
  logic [PRE_CNT_W-1:0] lim;

  assign lim        = pre_limit(code_i);
  assign pre_tick_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (pre_tick_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter never passes the odd prescale limit
  a_r2_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/swt_pow2_div.sv
module swt_pow2_div
  import swt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic             pre_tick_i,
  output logic             tick_o
);
  logic [POW_CNT_W-1:0] cnt_q;
  logic [POW_CNT_W-1:0] lim;

  // limit = 2^n - 1 as a thermometer mask
  for (genvar i = 0; i < POW_CNT_W; i++) begin : g_mask
    assign lim[i] = (32'(i) < 32'(pow_i));
  end

  assign tick_o = pre_tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else if (pre_tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter stays within 2^n - 1
  a_r2_pow_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  // R2: power stage advances only on prescaler ticks
  a_r2_pow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !pre_tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/swt_clkdiv.sv
module swt_clkdiv
  import swt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  output logic             tick_o
);
  div_t div_q;
  logic pre_tick;
  logic tick_c;
  logic tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (div_we_i) div_q <= div_t'(div_wdata_i);
  end

  swt_prescale u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (div_we_i),
    .code_i     (div_q.pre),
    .pre_tick_o (pre_tick)
  );

  swt_pow2_div u_pow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (div_we_i),
    .pow_i      (div_q.pow),
    .pre_tick_i (pre_tick),
    .tick_o     (tick_c)
  );

  // registered output; a write drops any tick of the old setting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tick_q <= 1'b0;
    else if (div_we_i) tick_q <= 1'b0;
    else               tick_q <= tick_c;
  end

  assign tick_o = tick_q;

  // R4: write suppresses the next cycle's tick
  a_r4_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_i |=> !tick_o);
  // R3: single-cycle pulse when dividing by more than one
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !div_we_i && div_q != '0) |=> !tick_o);
  // R6: divide by one ticks every clock
  a_r6_div1_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0 && !div_we_i) |=> tick_o);
endmodule

// File: tb/tb_swt_clkdiv.sv
module tb_swt_clkdiv;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       div_we_i = 1'b0;
  logic [4:0] div_wdata_i = '0;
  logic       tick_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  swt_clkdiv dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_we_i    (div_we_i),
    .div_wdata_i (div_wdata_i),
    .tick_o      (tick_o)
  );

  always #10 clk_i = ~clk_i;

  localparam int NV = 16;
  localparam logic [4:0] VDIV [NV] = '{5'h08, 5'h02, 5'h05, 5'h03, 5'h0C, 5'h06,
    5'h09, 5'h10, 5'h0A, 5'h0D, 5'h14, 5'h18, 5'h1C, 5'h01, 5'h1F, 5'h00};
  localparam int VN [NV] = '{4, 5, 6, 7, 8, 10, 12, 16, 20, 24, 32, 64, 128, 3, 896, 1};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count negedges until tick_o is seen high; returns the count
  task automatic wait_tick(output int k);
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (!tick_o && k < 2000);
  endtask

  // write at the next posedge; returns at the negedge after that edge
  task automatic wr(input logic [4:0] v);
    @(negedge clk_i);
    div_we_i = 1'b1;
    div_wdata_i = v;
    @(negedge clk_i);
    div_we_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    check("R1 tick low in reset", int'(tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 tick after reset release", int'(tick_o), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check("R1 R6 divide-by-one continuous", int'(tick_o), 1);
    end

    // R2 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VDIV[i]);
      check($sformatf("R4 low after write div=%0h", VDIV[i]), int'(tick_o), 0);
      wait_tick(k);
      check($sformatf("R2 R5 first tick div=%0h", VDIV[i]), k, VN[i]);
      if (VN[i] > 1) begin
        @(negedge clk_i);
        check($sformatf("R3 width div=%0h", VDIV[i]), int'(tick_o), 0);
        wait_tick(k);
        check($sformatf("R2 R7 period div=%0h", VDIV[i]), k + 1, VN[i]);
      end else begin
        @(negedge clk_i);
        check("R6 divide-by-one next cycle", int'(tick_o), 1);
      end
    end

    // R8 same-value rewrite mid-count
    wr(5'h1C);
    repeat (50) @(negedge clk_i);
    wr(5'h1C);
    check("R8 low after rewrite", int'(tick_o), 0);
    wait_tick(k);
    check("R8 restart same value", k, 128);

    // R8 different value mid-count
    wr(5'h1F);
    repeat (300) @(negedge clk_i);
    wr(5'h08);
    wait_tick(k);
    check("R8 restart new value", k, 4);

    // R4 write exactly when a tick would appear
    wr(5'h05);
    repeat (5) @(negedge clk_i);
    wr(5'h05);
    check("R4 tick suppressed on write", int'(tick_o), 0);
    wait_tick(k);
    check("R4 first tick after rewrite", k, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule